// File: doc/BRIEF.md
# Reset Supervisor with Activity Watchdog

This block is the digital part of a system reset supervisor. It drives two complementary reset pins, one active-low and one active-high, through open-drain style drive enables. When an enable is high, the pad drives its pin to the active level. When an enable is low, the pin floats to its passive level through an external pull resistor. The block also reads the pin levels back, so each reset pin doubles as a manual reset input.

A supply-good flag from an external comparator holds reset for as long as it is low. When the flag returns, reset stays asserted for a power-up interval and is then released. While reset is released, two kinds of event start a fresh timeout of the same length:
- a sensed edge of the active direction on either reset pin;
- expiry of a watchdog that is cleared by every transition of a monitored serial data line.

All intervals are counted in clock cycles and set by parameters. A build parameter removes the watchdog entirely.

Top module: `rst_supervisor`

## Requirements
- R1: While `supply_ok_i` is 0 at a rising clock edge, both drive enables are 1 from that edge on, and they stay 1 for as long as it is 0.
- R2: When `supply_ok_i` is 1 at an edge that finds the block holding for low supply, both enables stay 1 for exactly `PUR_CYCLES` further cycles. After that, both are 0 together.
- R3: While reset is released, a 0-to-1 change of `rst_hi_pin_i` starts a timeout. Both enables become 1 at the third rising edge that samples the new level, counting that edge as the first, and stay 1 for `PUR_CYCLES` cycles. Holding the pin high after that timeout, or returning it to 0, starts nothing.
- R4: While reset is released, a 1-to-0 change of `rst_lo_pin_i` starts a timeout with the same latency and length as in R3. Holding the pin low after that timeout, or returning it to 1, starts nothing.
- R5: With the watchdog built (`WDT_EN`=1), if `data_line_i` does not change for `WDT_CYCLES` consecutive released cycles, both enables become 1 and a timeout of `PUR_CYCLES` cycles follows.
- R6: Every rising or falling transition of `data_line_i` restarts the watchdog count, so a line that toggles at least once per `WDT_CYCLES` cycles keeps reset released.
- R7: The watchdog count holds at zero while reset is driven. After every release, a full `WDT_CYCLES` interval runs again.
- R8: With `WDT_EN`=0, a quiet `data_line_i` never causes a reset.
- R9: If `supply_ok_i` falls during a timeout, the block returns to holding. When `supply_ok_i` returns, a full `PUR_CYCLES` interval starts again.
- R10: Edges on the reset pins caused by the block's own drive never start another timeout. After a watchdog timeout, reset stays released for a full watchdog interval.
- R11: While `rst` is 1, both drive enables are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply above threshold, synchronous to `clk` |
| data_line_i | input | 1 | Monitored serial data line, asynchronous |
| rst_hi_pin_i | input | 1 | Sensed level of the active-high reset pin, asynchronous |
| rst_lo_pin_i | input | 1 | Sensed level of the active-low reset pin, asynchronous |
| rst_hi_drv_o | output | 1 | Drive enable: force the active-high pin high |
| rst_lo_drv_o | output | 1 | Drive enable: force the active-low pin low |

## Verification
The enables are decoded from one state register, so a supply change shows at the first edge that samples it. A pin edge passes two synchronizer flops and one history flop, so it shows at the third edge that samples it. A data-line edge has the same latency before it clears the watchdog. The bench holds a behavioural model that applies these same latencies to its own copy of the pin levels, and it compares both enables on every falling clock edge. Directed checks count the falling edges during which the enables hold one value, and compare that count with the exact `PUR_CYCLES` or `WDT_CYCLES` figure. Their latency checks sample the first, second and third falling edges after a pin change.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        PH_HOLD    = 2'd0,
        PH_TIMEOUT = 2'd1,
        PH_RUN     = 2'd2
    } phase_e;

    typedef struct packed {
        logic hi_pin;
        logic lo_pin;
        logic sda;
    } sense_t;

    localparam int unsigned SENSE_W = $bits(sense_t);

    localparam sense_t SENSE_IDLE = '{hi_pin: 1'b0, lo_pin: 1'b1, sda: 1'b0};
    localparam sense_t SENSE_RISE = '{hi_pin: 1'b1, lo_pin: 1'b0, sda: 1'b1};
    localparam sense_t SENSE_FALL = '{hi_pin: 1'b0, lo_pin: 1'b1, sda: 1'b1};

    typedef struct packed {
        logic man_hi;
        logic man_lo;
        logic wd_expire;
    } trig_t;

    function automatic logic any_trigger(input trig_t t);
        return t.man_hi | t.man_lo | t.wd_expire;
    endfunction

    function automatic logic is_driving(input phase_e p);
        return p != PH_RUN;
    endfunction

endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
    parameter int unsigned    W       = 3,
    parameter int unsigned    STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= RST_VAL;
        else     stage_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= RST_VAL;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rsv_edge.sv
module rsv_edge #(
    parameter int unsigned  W         = 3,
    parameter logic [W-1:0] RST_VAL   = '0,
    parameter logic [W-1:0] WATCH_UP  = '1,
    parameter logic [W-1:0] WATCH_DN  = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] hit_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= lvl_i;
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic up, dn;
        assign up       = lvl_i[b] & ~prev_q[b];
        assign dn       = ~lvl_i[b] & prev_q[b];
        assign hit_o[b] = (up & WATCH_UP[b]) | (dn & WATCH_DN[b]);
    end
endmodule

// File: rtl/rsv_watchdog.sv
module rsv_watchdog #(
    parameter int unsigned CYCLES = 160_000_000,
    localparam int unsigned WW    = $clog2(CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold_i,
    input  logic          kick_i,
    output logic          expire_o,
    output logic [WW-1:0] count_o
);
    localparam logic [WW-1:0] LAST = WW'(CYCLES - 1);

    logic [WW-1:0] cnt_q;

    assign expire_o = !hold_i && !kick_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || hold_i || kick_i) cnt_q <= '0;
        else if (cnt_q == LAST)      cnt_q <= '0;
        else                         cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/rsv_seq.sv
module rsv_seq
    import rsv_pkg::*;
#(
    parameter int unsigned PUR_CYCLES = 20_000_000,
    localparam int unsigned TW        = $clog2(PUR_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          supply_ok_i,
    input  trig_t         trig_i,
    output phase_e        phase_o,
    output logic [TW-1:0] tmr_o
);
    localparam logic [TW-1:0] TMR_LAST = TW'(PUR_CYCLES - 1);

    phase_e        phase_q;
    logic [TW-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HOLD;
            tmr_q   <= '0;
        end else if (!supply_ok_i) begin
            phase_q <= PH_HOLD;
            tmr_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_HOLD: begin
                    phase_q <= PH_TIMEOUT;
                    tmr_q   <= '0;
                end
                PH_TIMEOUT: begin
                    if (tmr_q == TMR_LAST) begin
                        phase_q <= PH_RUN;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                PH_RUN: begin
                    if (any_trigger(trig_i)) begin
                        phase_q <= PH_TIMEOUT;
                        tmr_q   <= '0;
                    end
                end
                default: begin
                    phase_q <= PH_HOLD;
                    tmr_q   <= '0;
                end
            endcase
        end
    end

    assign phase_o = phase_q;
    assign tmr_o   = tmr_q;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rsv_pkg::*;
#(
    parameter int unsigned PUR_CYCLES  = 20_000_000,
    parameter int unsigned WDT_CYCLES  = 160_000_000,
    parameter bit          WDT_EN      = 1'b1,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned TW         = $clog2(PUR_CYCLES + 1),
    localparam int unsigned WW         = $clog2(WDT_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok_i,
    input  logic data_line_i,
    input  logic rst_hi_pin_i,
    input  logic rst_lo_pin_i,
    output logic rst_hi_drv_o,
    output logic rst_lo_drv_o
);
    sense_t        raw, synced, hits;
    phase_e        phase;
    logic [TW-1:0] tmr_q;
    logic [WW-1:0] wd_count;
    logic          wd_hold, wd_kick, wd_expire, released;
    trig_t         trig;

    assign raw = '{hi_pin: rst_hi_pin_i, lo_pin: rst_lo_pin_i, sda: data_line_i};

    rsv_sync #(
        .W(SENSE_W), .STAGES(SYNC_STAGES), .RST_VAL(SENSE_IDLE)
    ) u_sync (
        .clk(clk), .rst(rst), .d_i(raw), .q_o(synced)
    );

    rsv_edge #(
        .W(SENSE_W), .RST_VAL(SENSE_IDLE),
        .WATCH_UP(SENSE_RISE), .WATCH_DN(SENSE_FALL)
    ) u_edge (
        .clk(clk), .rst(rst), .lvl_i(synced), .hit_o(hits)
    );

    assign released = !is_driving(phase);
    assign wd_hold  = !released;
    assign wd_kick  = hits.sda;

    if (WDT_EN) begin : g_wd
        rsv_watchdog #(.CYCLES(WDT_CYCLES)) u_wd (
            .clk(clk), .rst(rst), .hold_i(wd_hold), .kick_i(wd_kick),
            .expire_o(wd_expire), .count_o(wd_count)
        );
    end else begin : g_no_wd
        assign wd_expire = 1'b0;
        assign wd_count  = '0;
    end

    // pin sensing is masked while the block itself drives the pins
    assign trig.man_hi    = hits.hi_pin & released;
    assign trig.man_lo    = hits.lo_pin & released;
    assign trig.wd_expire = wd_expire;

    rsv_seq #(.PUR_CYCLES(PUR_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .supply_ok_i(supply_ok_i), .trig_i(trig),
        .phase_o(phase), .tmr_o(tmr_q)
    );

    assign rst_hi_drv_o = !released;
    assign rst_lo_drv_o = !released;
endmodule

// File: rtl/rsv_checker.sv
module rsv_checker #(
    parameter int unsigned PUR_CYCLES = 20,
    parameter int unsigned TW         = 5,
    parameter int unsigned WW         = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          supply_ok_i,
    input logic          rst_hi_drv_o,
    input logic          rst_lo_drv_o,
    input logic [TW-1:0] tmr_q,
    input logic [WW-1:0] wd_count,
    input logic          wd_kick,
    input logic          wd_hold,
    input logic          wd_expire,
    input logic          man_hi,
    input logic          man_lo
);
    assert_supply_low_drives_R1: assert property (@(posedge clk) disable iff (rst)
        !supply_ok_i |=> (rst_hi_drv_o && rst_lo_drv_o));

    assert_release_after_full_count_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_lo_drv_o) |-> ($past(tmr_q) == TW'(PUR_CYCLES - 1)));

    assert_hi_pin_edge_resets_R3: assert property (@(posedge clk) disable iff (rst)
        man_hi |=> rst_hi_drv_o);

    assert_lo_pin_edge_resets_R4: assert property (@(posedge clk) disable iff (rst)
        man_lo |=> rst_lo_drv_o);

    assert_wd_expiry_resets_R5: assert property (@(posedge clk) disable iff (rst)
        wd_expire |=> (rst_hi_drv_o && rst_lo_drv_o));

    assert_kick_clears_count_R6: assert property (@(posedge clk) disable iff (rst)
        (wd_kick && !wd_hold) |=> (wd_count == '0));

    assert_wd_held_in_reset_R7: assert property (@(posedge clk) disable iff (rst)
        rst_lo_drv_o |=> (wd_count == '0));

    assert_supply_drop_restarts_R9: assert property (@(posedge clk) disable iff (rst)
        !supply_ok_i |=> (tmr_q == '0));

    assert_timeout_not_cut_R10: assert property (@(posedge clk) disable iff (rst)
        (rst_lo_drv_o && supply_ok_i && tmr_q != TW'(PUR_CYCLES - 1)) |=> rst_lo_drv_o);
endmodule

bind rst_supervisor rsv_checker #(
    .PUR_CYCLES(PUR_CYCLES), .TW(TW), .WW(WW)
) u_chk (
    .clk(clk), .rst(rst), .supply_ok_i(supply_ok_i),
    .rst_hi_drv_o(rst_hi_drv_o), .rst_lo_drv_o(rst_lo_drv_o),
    .tmr_q(tmr_q), .wd_count(wd_count), .wd_kick(wd_kick),
    .wd_hold(wd_hold), .wd_expire(wd_expire),
    .man_hi(trig.man_hi), .man_lo(trig.man_lo)
);

// File: tb/rst_supervisor_tb.sv
module rsv_ref_model #(
    parameter int PUR    = 20,
    parameter int WDT    = 50,
    parameter bit WD_ON  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic supply,
    input  logic sda,
    input  logic ext_lo,
    input  logic ext_hi,
    output logic drive,
    output int   ph
);
    // ph: 0 = holding (low supply), 1 = timing out, 2 = released
    int         cnt = 0, wcnt = 0;
    logic [2:0] h1 = 3'b010, h2 = 3'b010, h3 = 3'b010; // {hi, lo, sda}
    logic [2:0] smp;
    bit         kick, lo_fall, hi_rise, expired, drv_now;

    initial begin
        ph    = 0;
        drive = 1'b1;
    end

    always @(posedge clk) begin
        drv_now = (ph != 2);
        smp = {drv_now | ext_hi, ~(drv_now | ext_lo), sda};
        if (rst) begin
            ph = 0; cnt = 0; wcnt = 0;
            h1 = 3'b010; h2 = 3'b010; h3 = 3'b010;
        end else begin
            kick    = (h2[0] != h3[0]);
            lo_fall = h3[1] && !h2[1];
            hi_rise = !h3[2] && h2[2];
            expired = 1'b0;
            if (ph == 2) begin
                if (kick) wcnt = 0;
                else if (wcnt == WDT - 1) begin wcnt = 0; expired = WD_ON; end
                else wcnt++;
            end else wcnt = 0;
            if (!supply) begin
                ph = 0; cnt = 0;
            end else if (ph == 0) begin
                ph = 1; cnt = 0;
            end else if (ph == 1) begin
                if (cnt == PUR - 1) begin ph = 2; cnt = 0; end
                else cnt++;
            end else if (lo_fall || hi_rise || expired) begin
                ph = 1; cnt = 0;
            end
            h3 = h2; h2 = h1; h1 = smp;
        end
        drive = (ph != 2);
    end
endmodule

module rst_supervisor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PUR        = 20;
    localparam int WDT        = 50;
    localparam int KICK_GAP   = 10;
    localparam int WD_LIMIT   = 150_000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply = 1'b1;
    logic sda = 1'b0;
    logic ext_lo = 1'b0, ext_hi = 1'b0;
    logic kick_en = 1'b0;
    logic cmp_en = 1'b0;

    logic a_hi_drv, a_lo_drv, b_hi_drv, b_lo_drv;
    logic a_hi_pin, a_lo_pin, b_hi_pin, b_lo_pin;
    logic m_a_drive, m_b_drive;
    int   m_a_ph, m_b_ph;

    int n_tests = 0, n_fail = 0, cyc = 0, kc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // pads: enable forces the active level, otherwise external pull or manual source
    assign a_hi_pin = a_hi_drv | ext_hi;
    assign a_lo_pin = ~(a_lo_drv | ext_lo);
    assign b_hi_pin = b_hi_drv | ext_hi;
    assign b_lo_pin = ~(b_lo_drv | ext_lo);

    rst_supervisor #(.PUR_CYCLES(PUR), .WDT_CYCLES(WDT), .WDT_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .supply_ok_i(supply), .data_line_i(sda),
        .rst_hi_pin_i(a_hi_pin), .rst_lo_pin_i(a_lo_pin),
        .rst_hi_drv_o(a_hi_drv), .rst_lo_drv_o(a_lo_drv)
    );

    rst_supervisor #(.PUR_CYCLES(PUR), .WDT_CYCLES(WDT), .WDT_EN(1'b0)) u_dut_nowd (
        .clk(clk), .rst(rst), .supply_ok_i(supply), .data_line_i(sda),
        .rst_hi_pin_i(b_hi_pin), .rst_lo_pin_i(b_lo_pin),
        .rst_hi_drv_o(b_hi_drv), .rst_lo_drv_o(b_lo_drv)
    );

    rsv_ref_model #(.PUR(PUR), .WDT(WDT), .WD_ON(1'b1)) m_a (
        .clk(clk), .rst(rst), .supply(supply), .sda(sda),
        .ext_lo(ext_lo), .ext_hi(ext_hi), .drive(m_a_drive), .ph(m_a_ph)
    );

    rsv_ref_model #(.PUR(PUR), .WDT(WDT), .WD_ON(1'b0)) m_b (
        .clk(clk), .rst(rst), .supply(supply), .sda(sda),
        .ext_lo(ext_lo), .ext_hi(ext_hi), .drive(m_b_drive), .ph(m_b_ph)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic string phase_tag(input int p);
        return (p == 0) ? "R1" : (p == 1) ? "R2" : "R5";
    endfunction

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (cmp_en) begin
            check(a_hi_drv == m_a_drive, {phase_tag(m_a_ph), " hi enable (wd)"}, int'(a_hi_drv), int'(m_a_drive));
            check(a_lo_drv == m_a_drive, {phase_tag(m_a_ph), " lo enable (wd)"}, int'(a_lo_drv), int'(m_a_drive));
            check(b_hi_drv == m_b_drive, "R8 hi enable (no wd)", int'(b_hi_drv), int'(m_b_drive));
            check(b_lo_drv == m_b_drive, "R8 lo enable (no wd)", int'(b_lo_drv), int'(m_b_drive));
        end
    end

    // data-line activity source
    always @(negedge clk) begin
        if (kick_en) begin
            kc++;
            if (kc >= KICK_GAP) begin
                kc  = 0;
                sda <= ~sda;
            end
        end else kc = 0;
    end

    // hang guard
    always @(posedge clk) begin
        cyc++;
        if (cyc >= WD_LIMIT) begin
            n_fail++;
            $display("FAIL hang guard: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // counts falling edges, starting at the current one, while the enable holds 'want'
    task automatic measure(input logic want, input int limit, output int n);
        n = 0;
        while (a_lo_drv == want && n < limit) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pin_latency(input string tag);
        @(negedge clk); check(a_lo_drv == 1'b0, {tag, " latency edge 1"}, int'(a_lo_drv), 0);
        @(negedge clk); check(a_lo_drv == 1'b0, {tag, " latency edge 2"}, int'(a_lo_drv), 0);
        @(negedge clk); check(a_lo_drv == 1'b1, {tag, " latency edge 3"}, int'(a_lo_drv), 1);
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        check(a_lo_drv && a_hi_drv, "R11 enables during rst", int'(a_lo_drv & a_hi_drv), 1);
        cmp_en = 1'b1;
        rst = 1'b0;
        @(negedge clk);
        measure(1'b1, 500, n); check(n == PUR, "R2 power-up interval", n, PUR);

        // quiet data line: watchdog expiry
        measure(1'b0, 500, n); check(n == WDT, "R5 watchdog interval", n, WDT);
        check(b_lo_drv == 1'b0, "R8 no-watchdog variant stays released", int'(b_lo_drv), 0);
        measure(1'b1, 500, n); check(n == PUR, "R5 watchdog timeout length", n, PUR);
        measure(1'b0, 500, n); check(n == WDT, "R7 R10 fresh interval after release", n, WDT);
        measure(1'b1, 500, n); check(n == PUR, "R7 second timeout length", n, PUR);

        // active data line keeps reset released
        kick_en = 1'b1;
        measure(1'b0, 300, n); check(n == 300, "R6 kicked watchdog", n, 300);

        // manual reset through the active-low pin, held at its active level
        ext_lo = 1'b1;
        pin_latency("R4");
        measure(1'b1, 500, n); check(n == PUR, "R4 manual timeout length", n, PUR);
        measure(1'b0, 150, n); check(n == 150, "R4 held level ignored", n, 150);
        ext_lo = 1'b0;
        measure(1'b0, 60, n); check(n == 60, "R4 release edge ignored", n, 60);

        // manual reset through the active-high pin
        ext_hi = 1'b1;
        pin_latency("R3");
        measure(1'b1, 500, n); check(n == PUR, "R3 manual timeout length", n, PUR);
        measure(1'b0, 150, n); check(n == 150, "R3 held level ignored", n, 150);
        ext_hi = 1'b0;
        measure(1'b0, 60, n); check(n == 60, "R3 release edge ignored", n, 60);

        // supply loss while released
        supply = 1'b0;
        @(negedge clk); check(a_lo_drv && a_hi_drv, "R1 supply low asserts", int'(a_lo_drv), 1);
        repeat (5) begin
            @(negedge clk); check(a_lo_drv && a_hi_drv, "R1 supply low holds", int'(a_lo_drv), 1);
        end
        supply = 1'b1;
        @(negedge clk);
        measure(1'b1, 500, n); check(n == PUR, "R2 interval after supply return", n, PUR);

        // supply loss during a timeout
        ext_hi = 1'b1;
        repeat (3) @(negedge clk);
        ext_hi = 1'b0;
        repeat (7) @(negedge clk);
        supply = 1'b0;
        @(negedge clk); check(a_lo_drv == 1'b1, "R9 drop during timeout", int'(a_lo_drv), 1);
        repeat (3) @(negedge clk);
        supply = 1'b1;
        @(negedge clk);
        measure(1'b1, 500, n); check(n == PUR, "R9 full restart", n, PUR);

        // no-watchdog build under a quiet line
        kick_en = 1'b0;
        n = 0;
        repeat (200) begin
            @(negedge clk);
            if (b_lo_drv == 1'b0) n++;
        end
        check(n == 200, "R8 quiet line without watchdog", n, 200);

        cmp_en = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule